// File: doc/BRIEF.md
# Shared Timer Prescaler and Watchdog Postscaler

This block holds an 8-bit timer/counter, a watchdog counter and one 8-bit divider that serves whichever of the two currently owns it. A mode register chooses the owner, the division ratio, the timer's count source and the edge of the external count pin. When the timer owns the divider, it divides the timer's count events and the watchdog advances once per time-base pulse. When the watchdog owns it, it divides the watchdog time base and the timer counts every event. Software can neither read nor load the divider. The owner's own clear action resets it: a timer register write when the timer owns it, and a watchdog clear strobe when the watchdog owns it.

Ownership can be moved while the block runs. The owner and the ratio pass through a register before they steer the divider, so a change of ratio cannot produce a short pulse. Moving the divider to the watchdog side raises no reset if a watchdog clear comes before the mode write.

Top module: `shared_divider_timer`

## Requirements
- R1: A synchronous reset sets the mode register to 0xFF, the timer count to 0, the overflow flag to 0 and the watchdog counter to 0, and holds `wdt_reset` low.
- R2: A mode write appears on `mode_value` on the next cycle. Its fields are: bit 5 selects the count source (0 = every clock cycle, 1 = external pin), bit 4 selects the pin edge (0 = rising, 1 = falling), bit 3 selects the divider owner (0 = timer, 1 = watchdog), and bits 2:0 hold the ratio select n. Bits 7:6 are stored without any effect.
- R3: While the timer owns the divider, the timer advances once every 2^(n+1) accepted count events, from 1:2 at n=0 up to 1:256 at n=7.
- R4: While the watchdog owns the divider, the timer advances on every accepted count event, and the watchdog counter advances once every 2^n time-base pulses (1:1 up to 1:128).
- R5: While the timer owns the divider, the watchdog counter advances on every time-base pulse.
- R6: The external pin passes through two synchronizer flops. A selected edge applied before clock edge k advances the count source at edge k+2.
- R7: A timer write loads the count on the next edge and takes priority over counting. The next two count events after it are discarded and do not reach the divider. While the timer owns the divider, the write also clears the divider.
- R8: On a count step from 0xFF to 0x00, the overflow flag sets and stays set until `ovf_clr`. If a set and a clear fall in the same cycle, the set wins.
- R9: `wdt_clr` clears the watchdog counter and takes priority over its advance. While the watchdog owns the divider, it also clears the divider.
- R10: An enabled watchdog that advances from all ones raises `wdt_reset` for exactly one cycle, on the next cycle, and then restarts from 0. A disabled watchdog never raises it.
- R11: A change to the owner bit or the ratio field steers the divider from the second edge after the mode write.
- R12: A watchdog clear followed by a move of the divider from the timer to the watchdog raises no watchdog reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| tmr_we | input | 1 | Timer count write strobe |
| tmr_wdata | input | TMR_W | Timer count write value |
| ovf_clr | input | 1 | Clears the overflow flag |
| cnt_pin | input | 1 | Asynchronous external count pin |
| wdt_base | input | 1 | Watchdog time-base pulse, one cycle wide |
| wdt_en | input | 1 | Watchdog enable |
| wdt_clr | input | 1 | Watchdog clear strobe |
| tmr_count | output | TMR_W | Timer count |
| tmr_ovf | output | 1 | Sticky timer overflow flag |
| mode_value | output | 8 | Current mode register |
| wdt_reset | output | 1 | One-cycle watchdog reset pulse |

## Verification
Each output has a fixed latency from its stimulus. Mode, timer loads and overflow changes appear one edge after the strobe. A new owner or ratio steers from the second edge. A pin edge counts at the second edge after it is captured. A watchdog reset appears one edge after the terminal advance. The bench model advances its state on each rising edge from the inputs held stable since the previous falling edge, and every output is compared with the model at the following falling edge. This keeps each comparison aligned with the cycle the result is due in. The directed checks count a fixed number of falling edges after the strobe, taken from these latencies, including the two discarded events after a timer write.

// File: rtl/shdiv_pkg.sv
package shdiv_pkg;
  // Mode register layout; the owner bit and ratio field steer the divider.
  typedef struct packed {
    logic [1:0] spare;
    logic       src_ext;
    logic       fall_edge;
    logic       to_wdt;
    logic [2:0] sel;
  } mode_t;

  localparam logic [7:0] MODE_RESET = 8'hFF;
endpackage

// File: rtl/shdiv_edge_src.sv
module shdiv_edge_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic src_ext,
  input  logic fall_edge,
  output logic src_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   cur;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= cur;
  end

  always_comb begin
    if (!src_ext)       src_evt = 1'b1;
    else if (fall_edge) src_evt = last_q & ~cur;
    else                src_evt = ~last_q & cur;
  end
endmodule

// File: rtl/shdiv_divider.sv
module shdiv_divider #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             to_wdt,
  input  logic [SEL_W-1:0] sel,
  input  logic             tmr_evt,
  input  logic             wdt_base,
  input  logic             tmr_we,
  input  logic             wdt_clr,
  output logic             tmr_tick,
  output logic             wdt_step
);
  localparam int RW = DIV_W + 1;
  localparam int RST_SPAN = 1 << ((1 << SEL_W) - 1);
  localparam logic [DIV_W-1:0] MASK_RST = DIV_W'(RST_SPAN - 1);

  logic             to_wdt_q;
  logic [DIV_W-1:0] mask_q;
  logic [DIV_W-1:0] mask_d;
  logic [DIV_W-1:0] div_q;
  logic [RW-1:0]    span;
  logic             adv;
  logic             clr;
  logic             hit;

  // Ratio span: watchdog side 2^n, timer side 2^(n+1).
  always_comb begin
    span   = to_wdt ? (RW'(1) << sel) : (RW'(2) << sel);
    mask_d = DIV_W'(span - RW'(1));
  end

  // Selection is registered so a ratio change cannot cut a pulse short.
  always_ff @(posedge clk) begin
    if (rst) begin
      to_wdt_q <= 1'b1;
      mask_q   <= MASK_RST;
    end else begin
      to_wdt_q <= to_wdt;
      mask_q   <= mask_d;
    end
  end

  assign adv = to_wdt_q ? wdt_base : tmr_evt;
  assign clr = to_wdt_q ? wdt_clr  : tmr_we;
  assign hit = adv && ((div_q & mask_q) == mask_q);

  always_ff @(posedge clk) begin
    if (rst)      div_q <= '0;
    else if (clr) div_q <= '0;
    else if (adv) div_q <= div_q + DIV_W'(1);
  end

  assign tmr_tick = to_wdt_q ? tmr_evt : hit;
  assign wdt_step = to_wdt_q ? hit : wdt_base;

  // R9: a clear by the owner leaves the divider at zero
  assert_div_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (to_wdt_q && wdt_clr) |=> (div_q == '0));
  // R7: a timer write on the timer side leaves the divider at zero
  assert_div_twrite_R7: assert property (@(posedge clk) disable iff (rst)
    (!to_wdt_q && tmr_we) |=> (div_q == '0));
endmodule

// File: rtl/shdiv_timer.sv
module shdiv_timer #(
  parameter int TMR_W = 8,
  parameter int HOLD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_evt,
  input  logic             tmr_tick,
  input  logic             tmr_we,
  input  logic [TMR_W-1:0] tmr_wdata,
  input  logic             ovf_clr,
  output logic             evt_pass,
  output logic [TMR_W-1:0] count,
  output logic             ovf
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] hold_q;

  assign evt_pass = src_evt && (hold_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (tmr_we)                       hold_q <= HW'(HOLD);
      else if (src_evt && hold_q != '0) hold_q <= hold_q - HW'(1);

      if (tmr_we)        count <= tmr_wdata;
      else if (tmr_tick) count <= count + TMR_W'(1);

      if (tmr_tick && !tmr_we && count == '1) ovf <= 1'b1;
      else if (ovf_clr)                       ovf <= 1'b0;
    end
  end

  // R7: a write lands on the next edge
  assert_tmr_load_R7: assert property (@(posedge clk) disable iff (rst)
    tmr_we |=> (count == $past(tmr_wdata)));
  // R8: the flag holds until cleared
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);
  // R8: the wrap sets the flag
  assert_ovf_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (tmr_tick && !tmr_we && count == '1) |=> (ovf && count == '0));
endmodule

// File: rtl/shdiv_watchdog.sv
module shdiv_watchdog #(
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic step,
  input  logic clr,
  output logic fire
);
  logic [WDT_W-1:0] cnt_q;
  logic             term;

  assign term = en && step && !clr && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      fire  <= 1'b0;
    end else begin
      fire <= term;
      if (clr)              cnt_q <= '0;
      else if (en && step)  cnt_q <= cnt_q + WDT_W'(1);
    end
  end

  // R9: a clear empties the counter and suppresses a reset
  assert_wdt_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0 && !fire));
  // R10: the reset lasts one cycle
  assert_fire_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
  // R10: a disabled watchdog stays quiet
  assert_fire_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !fire);
endmodule

// File: rtl/shared_divider_timer.sv
module shared_divider_timer
  import shdiv_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int DIV_W       = 8,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  logic [7:0]       mode_wdata,
  input  logic             tmr_we,
  input  logic [TMR_W-1:0] tmr_wdata,
  input  logic             ovf_clr,
  input  logic             cnt_pin,
  input  logic             wdt_base,
  input  logic             wdt_en,
  input  logic             wdt_clr,
  output logic [TMR_W-1:0] tmr_count,
  output logic             tmr_ovf,
  output logic [7:0]       mode_value,
  output logic             wdt_reset
);
  localparam int SEL_W = 3;

  mode_t mode_q;
  logic  src_evt;
  logic  evt_pass;
  logic  tmr_tick;
  logic  wdt_step;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= mode_t'(MODE_RESET);
    else if (mode_we) mode_q <= mode_t'(mode_wdata);
  end

  assign mode_value = mode_q;

  shdiv_edge_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk       (clk),
    .rst       (rst),
    .pin       (cnt_pin),
    .src_ext   (mode_q.src_ext),
    .fall_edge (mode_q.fall_edge),
    .src_evt   (src_evt)
  );

  shdiv_divider #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .to_wdt   (mode_q.to_wdt),
    .sel      (mode_q.sel),
    .tmr_evt  (evt_pass),
    .wdt_base (wdt_base),
    .tmr_we   (tmr_we),
    .wdt_clr  (wdt_clr),
    .tmr_tick (tmr_tick),
    .wdt_step (wdt_step)
  );

  shdiv_timer #(.TMR_W(TMR_W), .HOLD(HOLD)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .src_evt   (src_evt),
    .tmr_tick  (tmr_tick),
    .tmr_we    (tmr_we),
    .tmr_wdata (tmr_wdata),
    .ovf_clr   (ovf_clr),
    .evt_pass  (evt_pass),
    .count     (tmr_count),
    .ovf       (tmr_ovf)
  );

  shdiv_watchdog #(.WDT_W(WDT_W)) u_wdt (
    .clk  (clk),
    .rst  (rst),
    .en   (wdt_en),
    .step (wdt_step),
    .clr  (wdt_clr),
    .fire (wdt_reset)
  );

  // R2: a mode write shows on the next cycle
  assert_mode_load_R2: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> (mode_value == $past(mode_wdata)));
endmodule

// File: tb/shared_divider_timer_bench.sv
module shared_divider_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_we = 0, tmr_we = 0, ovf_clr = 0, cnt_pin = 0;
  logic       wdt_base = 0, wdt_en = 0, wdt_clr = 0;
  logic [7:0] mode_wdata = 0, tmr_wdata = 0;
  logic [7:0] tmr_count, mode_value;
  logic       tmr_ovf, wdt_reset;

  int n_chk = 0, n_fail = 0, cyc = 0, base_div = 0, pin_half = 0, fire_seen = 0;
  bit done = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  shared_divider_timer u_shared_divider_timer (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .ovf_clr(ovf_clr),
    .cnt_pin(cnt_pin), .wdt_base(wdt_base), .wdt_en(wdt_en), .wdt_clr(wdt_clr),
    .tmr_count(tmr_count), .tmr_ovf(tmr_ovf), .mode_value(mode_value),
    .wdt_reset(wdt_reset)
  );

  // Behavioural reference: event counting in integers.
  int m_mode, m_own, m_ratio, m_div, m_hold, m_tmr, m_ovf, m_wcnt, m_fire;
  bit pinq[$];

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 255; m_own = 1; m_ratio = 128; m_div = 0; m_hold = 0;
      m_tmr = 0; m_ovf = 0; m_wcnt = 0; m_fire = 0;
      pinq = '{0, 0, 0};
    end else begin
      bit cur, prv, ev, pass, adv, hit, tt, ws, cd;
      int sel;
      cur = pinq[1]; prv = pinq[2];
      if (m_mode[5] == 0)      ev = 1;
      else if (m_mode[4] == 1) ev = prv && !cur;
      else                     ev = !prv && cur;
      pass = ev && (m_hold == 0);
      adv  = m_own ? wdt_base : pass;
      hit  = adv && (((m_div + 1) % m_ratio) == 0);
      tt   = m_own ? pass : hit;
      ws   = m_own ? hit : wdt_base;
      cd   = m_own ? wdt_clr : tmr_we;
      m_fire = (wdt_en && ws && m_wcnt == 255 && !wdt_clr) ? 1 : 0;
      if (wdt_clr) m_wcnt = 0; else if (wdt_en && ws) m_wcnt = (m_wcnt + 1) % 256;
      if (tt && !tmr_we && m_tmr == 255) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (tmr_we) m_tmr = tmr_wdata; else if (tt) m_tmr = (m_tmr + 1) % 256;
      if (tmr_we) m_hold = 2; else if (ev && m_hold > 0) m_hold--;
      if (cd) m_div = 0; else if (adv) m_div = (m_div + 1) % 256;
      sel = m_mode % 8;
      m_own   = m_mode[3];
      m_ratio = m_mode[3] ? (1 << sel) : (2 << sel);
      if (mode_we) m_mode = mode_wdata;
      pinq.push_front(cnt_pin);
      void'(pinq.pop_back());
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check({phase, " tmr_count"}, tmr_count, m_tmr);
      check({phase, " tmr_ovf"}, tmr_ovf, m_ovf);
      check({phase, " mode_value"}, mode_value, m_mode);
      check({phase, " wdt_reset"}, wdt_reset, m_fire);
      if (wdt_reset) fire_seen++;
    end
  end

  task automatic tick();
    @(negedge clk);
    cyc++;
    mode_we = 0; tmr_we = 0; ovf_clr = 0; wdt_clr = 0;
    wdt_base = (base_div > 0) && (cyc % base_div == 0);
    if (pin_half > 0 && cyc % pin_half == 0) cnt_pin = !cnt_pin;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic write_mode(input logic [7:0] v);
    tick(); mode_we = 1; mode_wdata = v;
  endtask

  task automatic write_tmr(input logic [7:0] v);
    tick(); tmr_we = 1; tmr_wdata = v;
  endtask

  task automatic clear_wdt();
    tick(); wdt_clr = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    tick();
    // R1: reset state
    check("R1 mode", mode_value, 255);
    check("R1 tmr", tmr_count, 0);
    check("R1 ovf", tmr_ovf, 0);
    check("R1 wdt_reset", wdt_reset, 0);

    phase = "R2";
    write_mode(8'h00); tick();
    check("R2 mode", mode_value, 8'h00);
    run(4);

    // R3: 1:2 on timer side, two events discarded after the write
    phase = "R3";
    write_tmr(8'h00);
    run(4); check("R3 tmr before first step", tmr_count, 0);
    tick(); check("R3 tmr first step", tmr_count, 1);
    run(2); check("R3 tmr second step", tmr_count, 2);
    for (int s = 0; s < 8; s++) begin
      write_mode(8'(s)); run(3); write_tmr(8'h00); run(600);
    end

    phase = "R11";
    for (int k = 0; k < 30; k++) begin
      write_mode((k % 2) ? 8'h01 : 8'h05); run(3 + k % 5);
    end

    // R4 / R7: watchdog owns divider, timer counts every event
    phase = "R7";
    write_mode(8'h08); run(4);
    write_tmr(8'd10);
    run(3); check("R7 held after write", tmr_count, 10);
    tick(); check("R4 undivided count", tmr_count, 11);

    phase = "R8";
    write_tmr(8'hF0); run(20);
    check("R8 overflow set", tmr_ovf, 1);
    run(100); check("R8 overflow sticky", tmr_ovf, 1);
    tick(); tmr_we = 1; tmr_wdata = 8'h10; ovf_clr = 1;
    tick(); check("R8 overflow cleared", tmr_ovf, 0);
    check("R7 load", tmr_count, 8'h10);
    run(100); check("R8 stays clear", tmr_ovf, 0);

    phase = "R6";
    pin_half = 3;
    write_mode(8'h28); run(200);
    write_mode(8'h38); run(200);
    write_mode(8'h20); run(3); write_tmr(8'h00); run(200);
    pin_half = 0;

    phase = "R5";
    wdt_en = 1; base_div = 2;
    write_mode(8'h00); clear_wdt(); fire_seen = 0; run(600);
    check("R10 reset seen on timer side", fire_seen > 0, 1);

    phase = "R4";
    base_div = 1;
    write_mode(8'h0A); run(3); clear_wdt(); fire_seen = 0; run(1100);
    check("R4 reset seen on watchdog side", fire_seen > 0, 1);

    phase = "R9";
    write_mode(8'h08); run(3); fire_seen = 0;
    for (int k = 0; k < 20; k++) begin clear_wdt(); run(100); end
    check("R9 periodic clear holds off reset", fire_seen, 0);

    phase = "R12";
    write_mode(8'h00); run(3); clear_wdt(); run(240);
    fire_seen = 0;
    clear_wdt(); write_mode(8'h08); run(200);
    check("R12 no reset after reassign", fire_seen, 0);

    phase = "R10";
    wdt_en = 0; fire_seen = 0; run(600);
    check("R10 disabled watchdog quiet", fire_seen, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule